// File: doc/BRIEF.md
# Masked Vector Register Arithmetic Unit

This block holds a small file of vector registers and works through them one element per cycle. A single command moves a whole vector between the registers and a word-wide memory, adds two vectors element by element, or adds them under a per-element enable. The enable for each element comes from one bit of a 64-bit scalar mask register. A destination element whose enable bit is clear keeps the value it already held.

Commands arrive on a valid/ready port and carry an opcode, a destination index, two source indices, a mask register index and a base address. The unit accepts one command at a time. It keeps ready low until the command has finished, then raises a one-cycle done pulse. Mask registers are loaded through their own write port, one whole register per cycle, and that port is open at any time. A conditional add uses the mask value that was held when the command was accepted.

Top module: `vecMaskUnit`

## Requirements
- R1: After reset, cmdReady is 1, done is 0, memRdEn and memWrEn are 0, and every element of every vector register reads as zero.
- R2: Opcode 0 (load) writes memory word base+i into element i of the destination register for i = 0..63. It issues 64 reads at consecutive addresses, and read data returns one cycle after memRdEn.
- R3: Opcode 1 (store) writes element i of the register named by the first source field to address base+i for i = 0..63. It makes exactly 64 writes to consecutive addresses and touches no other address.
- R4: Opcode 2 (add) sets destination element i to the sum of element i of both sources, modulo 2^16, for every i.
- R5: Opcode 3 (masked add) sets destination element i to the 16-bit sum only when bit i of the selected mask register is 1, where bit 0 belongs to element 0. Elements whose bit is 0 keep their previous value.
- R6: An add or masked add whose destination equals one or both sources gives the arithmetically correct result, because each element is read before it is written.
- R7: cmdReady is low from the cycle after acceptance until the command ends. A cmdValid raised while the unit is busy is ignored.
- R8: done is high for exactly one cycle. For add, masked add and store it is high 64 cycles after the acceptance edge. For load it is high 65 cycles after that edge.
- R9: A masked add uses the mask contents sampled at acceptance. A mask write in the acceptance cycle, or while the command runs, does not affect that command, but it does affect later commands.
- R10: memRdEn and memWrEn are never high together. Both are low while the unit is idle and throughout an add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Unit idle and accepting a command |
| cmdOp | input | 2 | 0 load, 1 store, 2 add, 3 masked add |
| cmdDst | input | 2 | Destination vector register |
| cmdSrcA | input | 2 | First source vector register, also the store source |
| cmdSrcB | input | 2 | Second source vector register |
| cmdMask | input | 2 | Mask register for masked add |
| cmdBase | input | 16 | Base memory address for load and store |
| memAddr | output | 16 | Memory word address |
| memRdEn | output | 1 | Memory read request, data expected next cycle |
| memRdData | input | 16 | Memory read data |
| memWrEn | output | 1 | Memory write strobe |
| memWrData | output | 16 | Memory write data |
| maskWrEn | input | 1 | Mask register write strobe |
| maskWrIdx | input | 2 | Mask register being written |
| maskWrData | input | 64 | New mask value |
| done | output | 1 | One-cycle completion pulse |

## Verification
The mask write port and a masked add that reads the same mask register can act in the same cycle. The bench provokes this twice. First it raises maskWrEn to turn the selected mask from all zeros to all ones in the very cycle the command is accepted. Then it writes that mask again partway through the command. The stored destination vector must show that no element changed, and a following masked add with the same mask index must update every element.

// File: rtl/vmu_pkg.sv
package vmu_pkg;

  typedef enum logic [1:0] {
    OP_VLOAD  = 2'd0,
    OP_VSTORE = 2'd1,
    OP_VADD   = 2'd2,
    OP_VMADD  = 2'd3
  } vmuOp_e;

  // strobes from the sequencer to the register datapath
  typedef struct packed {
    logic snapMask;   // capture selected mask register
    logic vecWrEn;    // write one vector element
    logic wrFromMem;  // element data from memory instead of adder
    logic maskGate;   // qualify the write by the captured mask bit
  } vmuStrobe_t;

endpackage

// File: rtl/vmuControl.sv
module vmuControl
  import vmu_pkg::*;
#(
  parameter int NUM_ELEMS = 64,
  parameter int NUM_VREGS = 4,
  parameter int ADDR_W    = 16,
  localparam int IDX_W    = $clog2(NUM_ELEMS),
  localparam int VR_W     = $clog2(NUM_VREGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [1:0]        cmdOp,
  input  logic [VR_W-1:0]   cmdDst,
  input  logic [VR_W-1:0]   cmdSrcA,
  input  logic [VR_W-1:0]   cmdSrcB,
  input  logic [ADDR_W-1:0] cmdBase,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic              done,
  output vmuStrobe_t        strobe,
  output logic [VR_W-1:0]   dstSel,
  output logic [VR_W-1:0]   srcASel,
  output logic [VR_W-1:0]   srcBSel,
  output logic [IDX_W-1:0]  rdIdx,
  output logic [IDX_W-1:0]  wrIdx
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN} state_e;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ELEMS - 1);

  state_e            stateQ;
  vmuOp_e            opQ;
  logic [VR_W-1:0]   dstQ, srcAQ, srcBQ;
  logic [ADDR_W-1:0] baseQ;
  logic [IDX_W-1:0]  idxQ;
  logic [IDX_W-1:0]  wbIdxQ;
  logic              wbValidQ;
  logic              doneQ;
  logic              accept;
  logic              running;
  logic              isArith;

  assign accept  = cmdValid && (stateQ == S_IDLE);
  assign running = (stateQ == S_RUN);
  assign isArith = (opQ == OP_VADD) || (opQ == OP_VMADD);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= S_IDLE;
      opQ      <= OP_VLOAD;
      dstQ     <= '0;
      srcAQ    <= '0;
      srcBQ    <= '0;
      baseQ    <= '0;
      idxQ     <= '0;
      wbIdxQ   <= '0;
      wbValidQ <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (stateQ)
        S_IDLE: begin
          if (accept) begin
            opQ      <= vmuOp_e'(cmdOp);
            dstQ     <= cmdDst;
            srcAQ    <= cmdSrcA;
            srcBQ    <= cmdSrcB;
            baseQ    <= cmdBase;
            idxQ     <= '0;
            wbValidQ <= 1'b0;
            stateQ   <= S_RUN;
          end
        end
        S_RUN: begin
          idxQ <= idxQ + 1'b1;
          if (opQ == OP_VLOAD) begin
            // read data comes back next cycle: remember which element
            wbValidQ <= 1'b1;
            wbIdxQ   <= idxQ;
          end
          if (idxQ == LAST_IDX) begin
            if (opQ == OP_VLOAD) begin
              stateQ <= S_DRAIN;
            end else begin
              stateQ <= S_IDLE;
              doneQ  <= 1'b1;
            end
          end
        end
        S_DRAIN: begin
          wbValidQ <= 1'b0;
          stateQ   <= S_IDLE;
          doneQ    <= 1'b1;
        end
        default: stateQ <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cmdReady         = (stateQ == S_IDLE);
    memAddr          = baseQ + ADDR_W'(idxQ);
    memRdEn          = running && (opQ == OP_VLOAD);
    memWrEn          = running && (opQ == OP_VSTORE);
    strobe.snapMask  = accept;
    strobe.wrFromMem = (opQ == OP_VLOAD);
    strobe.maskGate  = (opQ == OP_VMADD);
    strobe.vecWrEn   = (opQ == OP_VLOAD) ? wbValidQ : (running && isArith);
    wrIdx            = (opQ == OP_VLOAD) ? wbIdxQ : idxQ;
    rdIdx            = idxQ;
    dstSel           = dstQ;
    srcASel          = srcAQ;
    srcBSel          = srcBQ;
    done             = doneQ;
  end

endmodule

// File: rtl/vmuDatapath.sv
module vmuDatapath
  import vmu_pkg::*;
#(
  parameter int NUM_ELEMS = 64,
  parameter int ELEM_W    = 16,
  parameter int NUM_VREGS = 4,
  parameter int NUM_MREGS = 4,
  localparam int IDX_W    = $clog2(NUM_ELEMS),
  localparam int VR_W     = $clog2(NUM_VREGS),
  localparam int MR_W     = $clog2(NUM_MREGS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  vmuStrobe_t           strobe,
  input  logic [VR_W-1:0]      dstSel,
  input  logic [VR_W-1:0]      srcASel,
  input  logic [VR_W-1:0]      srcBSel,
  input  logic [MR_W-1:0]      cmdMask,
  input  logic [IDX_W-1:0]     rdIdx,
  input  logic [IDX_W-1:0]     wrIdx,
  input  logic [ELEM_W-1:0]    memRdData,
  output logic [ELEM_W-1:0]    memWrData,
  input  logic                 maskWrEn,
  input  logic [MR_W-1:0]      maskWrIdx,
  input  logic [NUM_ELEMS-1:0] maskWrData
);

  logic [NUM_VREGS-1:0][ELEM_W-1:0]    regRd;
  logic [NUM_MREGS-1:0][NUM_ELEMS-1:0] maskAll;
  logic [NUM_ELEMS-1:0]                maskSnapQ;
  logic [ELEM_W-1:0]                   elemA, elemB, elemSum, wrData;
  logic                                gateOk;

  // per-register element storage, one read at rdIdx each
  for (genvar v = 0; v < NUM_VREGS; v++) begin : gVreg
    logic [ELEM_W-1:0] elems [NUM_ELEMS];
    logic              hit;
    assign hit = strobe.vecWrEn && gateOk && (dstSel == VR_W'(v));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int i = 0; i < NUM_ELEMS; i++) elems[i] <= '0;
      end else if (hit) begin
        elems[wrIdx] <= wrData;
      end
    end
    assign regRd[v] = elems[rdIdx];
  end

  // scalar mask registers, whole-register writes
  for (genvar m = 0; m < NUM_MREGS; m++) begin : gMreg
    logic [NUM_ELEMS-1:0] maskQ;
    always_ff @(posedge clk) begin
      if (!rstN) maskQ <= '0;
      else if (maskWrEn && (maskWrIdx == MR_W'(m))) maskQ <= maskWrData;
    end
    assign maskAll[m] = maskQ;
  end

  // mask seen by a running command is the value held at acceptance
  always_ff @(posedge clk) begin
    if (!rstN) maskSnapQ <= '0;
    else if (strobe.snapMask) maskSnapQ <= maskAll[cmdMask];
  end

  always_comb begin
    elemA     = regRd[srcASel];
    elemB     = regRd[srcBSel];
    elemSum   = elemA + elemB;
    wrData    = strobe.wrFromMem ? memRdData : elemSum;
    gateOk    = !strobe.maskGate || maskSnapQ[wrIdx];
    memWrData = elemA;
  end

endmodule

// File: rtl/vecMaskUnit.sv
module vecMaskUnit
  import vmu_pkg::*;
#(
  parameter int NUM_ELEMS = 64,
  parameter int ELEM_W    = 16,
  parameter int NUM_VREGS = 4,
  parameter int NUM_MREGS = 4,
  parameter int ADDR_W    = 16,
  localparam int IDX_W    = $clog2(NUM_ELEMS),
  localparam int VR_W     = $clog2(NUM_VREGS),
  localparam int MR_W     = $clog2(NUM_MREGS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  output logic                 cmdReady,
  input  logic [1:0]           cmdOp,
  input  logic [VR_W-1:0]      cmdDst,
  input  logic [VR_W-1:0]      cmdSrcA,
  input  logic [VR_W-1:0]      cmdSrcB,
  input  logic [MR_W-1:0]      cmdMask,
  input  logic [ADDR_W-1:0]    cmdBase,
  output logic [ADDR_W-1:0]    memAddr,
  output logic                 memRdEn,
  input  logic [ELEM_W-1:0]    memRdData,
  output logic                 memWrEn,
  output logic [ELEM_W-1:0]    memWrData,
  input  logic                 maskWrEn,
  input  logic [MR_W-1:0]      maskWrIdx,
  input  logic [NUM_ELEMS-1:0] maskWrData,
  output logic                 done
);

  vmuStrobe_t       strobe;
  logic [VR_W-1:0]  dstSel, srcASel, srcBSel;
  logic [IDX_W-1:0] rdIdx, wrIdx;

  vmuControl #(
    .NUM_ELEMS(NUM_ELEMS), .NUM_VREGS(NUM_VREGS), .ADDR_W(ADDR_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOp(cmdOp),
    .cmdDst(cmdDst), .cmdSrcA(cmdSrcA), .cmdSrcB(cmdSrcB), .cmdBase(cmdBase),
    .memAddr(memAddr), .memRdEn(memRdEn), .memWrEn(memWrEn), .done(done),
    .strobe(strobe), .dstSel(dstSel), .srcASel(srcASel), .srcBSel(srcBSel),
    .rdIdx(rdIdx), .wrIdx(wrIdx)
  );

  vmuDatapath #(
    .NUM_ELEMS(NUM_ELEMS), .ELEM_W(ELEM_W),
    .NUM_VREGS(NUM_VREGS), .NUM_MREGS(NUM_MREGS)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .dstSel(dstSel), .srcASel(srcASel), .srcBSel(srcBSel), .cmdMask(cmdMask),
    .rdIdx(rdIdx), .wrIdx(wrIdx),
    .memRdData(memRdData), .memWrData(memWrData),
    .maskWrEn(maskWrEn), .maskWrIdx(maskWrIdx), .maskWrData(maskWrData)
  );

endmodule

// File: rtl/vmuChecker.sv
module vmuChecker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRdEn,
  input logic              memWrEn,
  input logic              done
);

  p_mem_exclusive_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && memWrEn));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> (!memRdEn && !memWrEn));

  p_accept_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> !cmdReady);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> cmdReady);

  p_store_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && $past(memWrEn)) |-> (memAddr == $past(memAddr) + ADDR_W'(1)));

  p_load_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && $past(memRdEn)) |-> (memAddr == $past(memAddr) + ADDR_W'(1)));

endmodule

bind vecMaskUnit vmuChecker #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
  .memAddr(memAddr), .memRdEn(memRdEn), .memWrEn(memWrEn), .done(done)
);

// File: tb/vecMaskUnit_test.sv
`timescale 1ns/1ps
module vecMaskUnit_test;

  localparam int OPL = 0, OPS = 1, OPA = 2, OPM = 3;
  localparam int SB  = 600;  // store scratch base

  logic        clk = 1'b0;
  logic        rstN;
  logic        cmdValid, cmdReady;
  logic [1:0]  cmdOp, cmdDst, cmdSrcA, cmdSrcB, cmdMask;
  logic [15:0] cmdBase, memAddr, memRdData, memWrData;
  logic        memRdEn, memWrEn, maskWrEn, done;
  logic [1:0]  maskWrIdx;
  logic [63:0] maskWrData;

  logic [15:0] mem  [1024];
  logic [15:0] expV [4][64];
  logic [63:0] expM [4];
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  vecMaskUnit uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .cmdDst(cmdDst), .cmdSrcA(cmdSrcA), .cmdSrcB(cmdSrcB),
    .cmdMask(cmdMask), .cmdBase(cmdBase), .memAddr(memAddr), .memRdEn(memRdEn),
    .memRdData(memRdData), .memWrEn(memWrEn), .memWrData(memWrData),
    .maskWrEn(maskWrEn), .maskWrIdx(maskWrIdx), .maskWrData(maskWrData),
    .done(done)
  );

  // memory model: registered read, one cycle latency
  always @(posedge clk) begin
    if (memRdEn) memRdData <= mem[memAddr[9:0]];
    if (memWrEn) mem[memAddr[9:0]] <= memWrData;
  end

  task automatic chk(string req, string what, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic runCmd(input int op, dst, a, b, m, base,
                        input int pokeAt, input int accMaskIdx,
                        input int midAt, input int midIdx, input logic [63:0] mVal,
                        output int lat, output int writes, output int reads);
    int busyBad;
    busyBad = 0; writes = 0; reads = 0; lat = -1;
    @(negedge clk);
    while (!cmdReady) @(negedge clk);
    cmdOp = 2'(op); cmdDst = 2'(dst); cmdSrcA = 2'(a); cmdSrcB = 2'(b);
    cmdMask = 2'(m); cmdBase = 16'(base); cmdValid = 1'b1;
    if (accMaskIdx >= 0) begin
      maskWrEn = 1'b1; maskWrIdx = 2'(accMaskIdx); maskWrData = mVal;
    end
    @(negedge clk);
    cmdValid = 1'b0; maskWrEn = 1'b0;
    for (int k = 0; k < 300; k++) begin
      if (done) begin lat = k; break; end
      if (cmdReady) busyBad++;
      if (memWrEn) writes++;
      if (memRdEn) reads++;
      if (k == pokeAt) begin
        cmdValid = 1'b1; cmdOp = 2'(OPL); cmdDst = 2'd3; cmdBase = 16'd100;
      end
      if (k == midAt) begin
        maskWrEn = 1'b1; maskWrIdx = 2'(midIdx); maskWrData = mVal;
      end
      @(negedge clk);
      cmdValid = 1'b0; maskWrEn = 1'b0;
    end
    chk("R7", "ready high while busy", busyBad, 0);
    @(negedge clk);
    chk("R8", "done width", done, 0);
  endtask

  task automatic writeMask(input int idx, input logic [63:0] val);
    @(negedge clk);
    maskWrEn = 1'b1; maskWrIdx = 2'(idx); maskWrData = val;
    @(negedge clk);
    maskWrEn = 1'b0;
    expM[idx] = val;
  endtask

  task automatic doLoad(input int v, input int base);
    int lat, w, r;
    runCmd(OPL, v, 0, 0, 0, base, -1, -1, -1, 0, 0, lat, w, r);
    chk("R8", "load latency", lat, 65);
    chk("R2", "load read count", r, 64);
    chk("R10", "writes during load", w, 0);
    for (int i = 0; i < 64; i++) expV[v][i] = mem[base + i];
  endtask

  task automatic doStore(input int v, input string req);
    int lat, w, r;
    for (int i = -1; i <= 64; i++) mem[SB + i] <= 16'hDEAD;
    runCmd(OPS, 0, v, 0, 0, SB, -1, -1, -1, 0, 0, lat, w, r);
    chk("R8", "store latency", lat, 64);
    chk("R3", "store write count", w, 64);
    chk("R10", "reads during store", r, 0);
    chk("R3", "guard below", mem[SB - 1], 16'hDEAD);
    chk("R3", "guard above", mem[SB + 64], 16'hDEAD);
    for (int i = 0; i < 64; i++)
      chk(req, $sformatf("v%0d elem %0d", v, i), mem[SB + i], expV[v][i]);
  endtask

  task automatic doAdd(input int dst, a, b, input bit masked, input int m,
                       input logic [63:0] effMask, input int pokeAt,
                       input int accMaskIdx, input int midAt,
                       input logic [63:0] mVal);
    int lat, w, r;
    logic [15:0] s;
    runCmd(masked ? OPM : OPA, dst, a, b, m, 0, pokeAt, accMaskIdx, midAt,
           m, mVal, lat, w, r);
    chk("R8", "add latency", lat, 64);
    chk("R10", "memory use during add", w + r, 0);
    for (int i = 0; i < 64; i++) begin
      s = expV[a][i] + expV[b][i];
      if (!masked || effMask[i]) expV[dst][i] = s;
    end
  endtask

  initial begin
    rstN = 1'b0; cmdValid = 1'b0; cmdOp = '0; cmdDst = '0; cmdSrcA = '0;
    cmdSrcB = '0; cmdMask = '0; cmdBase = '0; maskWrEn = 1'b0;
    maskWrIdx = '0; maskWrData = '0;
    for (int i = 0; i < 1024; i++) mem[i] <= 16'hDEAD;
    for (int i = 0; i < 64; i++) begin
      mem[100 + i] <= 16'(i * 16'h0131 + 16'h0007);
      mem[200 + i] <= 16'hFF00 + 16'(i * 5);
      mem[300 + i] <= 16'h5A00 ^ 16'(i);
    end
    for (int v = 0; v < 4; v++) begin
      expM[v] = '0;
      for (int i = 0; i < 64; i++) expV[v][i] = '0;
    end
    repeat (5) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1", "cmdReady after reset", cmdReady, 1);
    chk("R1", "done after reset", done, 0);
    chk("R1", "memRdEn after reset", memRdEn, 0);
    chk("R1", "memWrEn after reset", memWrEn, 0);
    doStore(3, "R1");

    // R2: loads then read back
    doLoad(0, 100);
    doLoad(1, 200);
    doStore(0, "R2");
    doStore(1, "R2");

    // R4 with wrap-around; R7 poke while busy must not load v3
    doAdd(2, 0, 1, 0, 0, '0, 10, -1, -1, '0);
    doStore(2, "R4");
    doStore(3, "R7");

    // R5: masked add, edge bits set, and an all-zero mask
    writeMask(1, 64'h8000_00F0_0F00_A5A1);
    doLoad(3, 300);
    doAdd(3, 0, 1, 1, 1, expM[1], -1, -1, -1, '0);
    doStore(3, "R5");
    doAdd(2, 1, 1, 1, 2, expM[2], -1, -1, -1, '0);
    doStore(2, "R5");

    // R6: in-place forms
    doAdd(0, 0, 1, 0, 0, '0, -1, -1, -1, '0);
    doStore(0, "R6");
    doAdd(1, 1, 1, 0, 0, '0, -1, -1, -1, '0);
    doStore(1, "R6");

    // R9: mask 2 is zero at acceptance; writes at acceptance and mid-run
    doAdd(3, 0, 0, 1, 2, 64'h0, -1, 2, 20, 64'hFFFF_FFFF_FFFF_FFFF);
    expM[2] = 64'hFFFF_FFFF_FFFF_FFFF;
    doStore(3, "R9");
    doAdd(3, 0, 0, 1, 2, expM[2], -1, -1, -1, '0);
    doStore(3, "R9");

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule